// File: doc/BRIEF.md
# Serial OSD Command Parser

This block receives write commands for an on-screen-display character memory over a four-wire-style serial link. A small SPI receiver turns the serial bits into bytes. A format state machine then decides whether each byte is a row address, a column address or a character to store. Each stored character leaves the block as a one-clock write strobe, with a 9-bit memory address and an 8-bit data value.

Bits 7 and 6 of each byte set its role. A host can send row, column and data for every item. It can also keep one row and repeat only column and data. For bulk loading it can enter a streaming mode in which every later byte is data and the address advances on its own. Streaming mode lasts until the select line is released.

The serial inputs are treated as asynchronous. They are synchronised to the system clock, and the serial clock edges are found by sampling, so the system clock must be several times faster than the serial clock.

Top module: `osd_cmd_parser`

## Requirements
- R1: While `spi_sel_n` is low, each rising edge of `spi_sck` shifts in one `spi_mosi` bit, most significant bit first. Every eight bits form one byte. When `spi_sel_n` goes high, any byte that is only partly received is discarded.
- R2: A byte with bit 7 = 1 is a row address, and its bits 3..0 give the row. It produces no write. A row byte received while the parser waits for a column replaces the stored row.
- R3: A byte with bit 7 = 0 and bit 6 = 0, received after a row byte or after a per-item data byte, is a column address. Its bits 4..0 give the column. The next byte is treated as data.
- R4: In per-item mode, the data byte is written once, to address row*32 + column (`wr_addr` = {row[3:0], col[4:0]}). After that write, the next byte is decoded again as a row or a column. A column byte on its own reuses the stored row.
- R5: A byte with bit 7 = 0 and bit 6 = 1 is a column address that starts bulk mode. Every byte that follows is data. Each is written at the current address, and the address then advances by one. Column 31 wraps to column 0 with the row increased by one, and row 15, column 31 wraps to row 0, column 0.
- R6: Once in bulk mode, bytes with bit 7 set or bit 6 set are still written as data. Bulk mode is left only when `spi_sel_n` goes high.
- R7: When `spi_sel_n` goes high, the parser returns to idle. In a new transaction, bytes received before the first row byte are ignored and produce no write.
- R8: `wr_en` is high for exactly one clock for each data byte and is low at all other times, including after reset. `wr_addr` and `wr_data` are valid during that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sel_n | input | 1 | Serial select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, idle low, asynchronous |
| spi_mosi | input | 1 | Serial data, sampled on the rising edge of the serial clock |
| wr_en | output | 1 | One-clock write strobe to the display memory |
| wr_addr | output | 9 | Write address, {row[3:0], column[4:0]} |
| wr_data | output | 8 | Write data |

## Verification
The assertions assume three things about the inputs:
- each level of `spi_sck` lasts longer than the synchroniser depth plus one system clock;
- `spi_mosi` is settled before the rising edge of `spi_sck`;
- `spi_sel_n` never changes at the same moment as a serial clock edge.

Under these conditions a received byte and an end of transaction never fall in the same clock. The stimulus holds each serial clock level for four system clocks and changes the data line only while the serial clock is low. It also waits several clocks before and after each select transition.

// File: rtl/osd_pkg.sv
package osd_pkg;

    localparam int ROW_W       = 4;
    localparam int COL_W       = 5;
    localparam int ADDR_W      = ROW_W + COL_W;
    localparam int BYTE_W      = 8;
    localparam int BIT_CNT_W   = $clog2(BYTE_W);
    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL_AB,
        ST_DATA_AB,
        ST_COL_C,
        ST_DATA_C
    } fmt_state_e;

    typedef enum logic [1:0] {
        ROLE_ROW,
        ROLE_COL_AB,
        ROLE_COL_C
    } byte_role_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } loc_t;

    function automatic byte_role_e byte_role(input logic [BYTE_W-1:0] b);
        if (b[7])      return ROLE_ROW;
        else if (b[6]) return ROLE_COL_C;
        else           return ROLE_COL_AB;
    endfunction

endpackage

// File: rtl/osd_sync.sv
module osd_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/osd_spi_rx.sv
module osd_spi_rx
    import osd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              xact_end
);
    logic [2:0]           synced;
    logic                 s_sel, s_sck, s_mosi;
    logic                 sck_q, sel_q;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0]    shreg;
    logic                 sck_rise, sel_rise;

    osd_sync #(.STAGES(SYNC_STAGES), .W(3)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sel_n, sck, mosi}),
        .q   (synced)
    );

    assign {s_sel, s_sck, s_mosi} = synced;
    assign sck_rise = s_sck & ~sck_q;
    assign sel_rise = s_sel & ~sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b1;
            sel_q     <= 1'b1;
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            xact_end  <= 1'b0;
        end else begin
            sck_q    <= s_sck;
            sel_q    <= s_sel;
            byte_vld <= 1'b0;
            xact_end <= sel_rise;
            if (s_sel) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[BYTE_W-3:0], s_mosi};
                if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                    byte_vld  <= 1'b1;
                    byte_data <= {shreg, s_mosi};
                    bit_cnt   <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/osd_fmt_fsm.sv
module osd_fmt_fsm
    import osd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              xact_end,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output fmt_state_e        state
);
    loc_t       loc;
    byte_role_e role;

    assign role = byte_role(byte_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            loc     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (xact_end) begin
                state <= ST_IDLE;
            end else if (byte_vld) begin
                case (state)
                    ST_IDLE: begin
                        if (role == ROLE_ROW) begin
                            loc.row <= byte_data[ROW_W-1:0];
                            state   <= ST_ROW;
                        end
                    end
                    ST_ROW, ST_DATA_AB: begin
                        case (role)
                            ROLE_ROW: begin
                                loc.row <= byte_data[ROW_W-1:0];
                                state   <= ST_ROW;
                            end
                            ROLE_COL_AB: begin
                                loc.col <= byte_data[COL_W-1:0];
                                state   <= ST_COL_AB;
                            end
                            default: begin
                                loc.col <= byte_data[COL_W-1:0];
                                state   <= ST_COL_C;
                            end
                        endcase
                    end
                    ST_COL_AB: begin
                        wr_en   <= 1'b1;
                        wr_addr <= loc;
                        wr_data <= byte_data;
                        state   <= ST_DATA_AB;
                    end
                    default: begin
                        wr_en   <= 1'b1;
                        wr_addr <= loc;
                        wr_data <= byte_data;
                        loc     <= loc + 1'b1;
                        state   <= ST_DATA_C;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/osd_cmd_parser.sv
module osd_cmd_parser
    import osd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sel_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    logic              byte_vld;
    logic [BYTE_W-1:0] rx_byte;
    logic              xact_end;
    fmt_state_e        fsm_state;

    osd_spi_rx i_rx (
        .clk       (clk),
        .rst       (rst),
        .sel_n     (spi_sel_n),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .byte_vld  (byte_vld),
        .byte_data (rx_byte),
        .xact_end  (xact_end)
    );

    osd_fmt_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_data (rx_byte),
        .xact_end  (xact_end),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .state     (fsm_state)
    );
endmodule

// File: rtl/osd_cmd_parser_chk.sv
module osd_cmd_parser_chk
    import osd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       byte_vld,
    input logic       xact_end,
    input fmt_state_e fsm_state
);
    // R8: a strobe never lasts two clocks
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R8: a strobe always follows a received byte
    a_r8_strobe_from_byte: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(byte_vld));

    // R6: bulk mode is left only at the end of a transaction
    a_r6_bulk_sticky: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_DATA_C && !xact_end) |=> fsm_state == ST_DATA_C);

    // R7: end of transaction returns to idle
    a_r7_end_idle: assert property (@(posedge clk) disable iff (rst)
        xact_end |=> fsm_state == ST_IDLE);

    // R7: no write out of idle
    a_r7_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_IDLE && byte_vld) |=> !wr_en);

    // R2: a row byte never writes
    a_r2_row_no_write: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_ROW && byte_vld) |=> !wr_en);
endmodule

bind osd_cmd_parser osd_cmd_parser_chk i_chk (.*);

// File: tb/test_osd_cmd_parser.sv
module test_osd_cmd_parser;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sel_n = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       wr_en;
    logic [8:0] wr_addr;
    logic [7:0] wr_data;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    running  = 1'b0;
    bit    prev_wr  = 1'b0;
    int    exp_addr[$];
    int    exp_data[$];
    string exp_tag[$];

    // behavioural reference: 0 idle, 1 row, 2 column a/b, 3 data a/b, 4 bulk
    int m_state = 0;
    int m_row   = 0;
    int m_col   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osd_cmd_parser i_osd_cmd_parser (
        .clk(clk), .rst(rst), .spi_sel_n(spi_sel_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_byte(input logic [7:0] b, input string tag);
        case (m_state)
            0: if (b[7]) begin m_row = b[3:0]; m_state = 1; end
            1, 3: begin
                if (b[7])      begin m_row = b[3:0]; m_state = 1; end
                else if (b[6]) begin m_col = b[4:0]; m_state = 4; end
                else           begin m_col = b[4:0]; m_state = 2; end
            end
            2: begin
                exp_addr.push_back(m_row * 32 + m_col);
                exp_data.push_back(b);
                exp_tag.push_back(tag);
                m_state = 3;
            end
            default: begin
                exp_addr.push_back(m_row * 32 + m_col);
                exp_data.push_back(b);
                exp_tag.push_back(tag);
                m_col++;
                if (m_col == 32) begin
                    m_col = 0;
                    m_row = (m_row + 1) % 16;
                end
            end
        endcase
    endtask

    task automatic spi_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = b[i];
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        model_byte(b, tag);
        spi_bits(b, 8);
    endtask

    task automatic xact_begin();
        spi_sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xact_finish(input string tag);
        repeat (HALF + 4) @(negedge clk);
        spi_sel_n = 1'b1;
        m_state = 0;
        repeat (8) @(negedge clk);
        check(exp_addr.size() == 0, tag, "pending expected writes", exp_addr.size(), 0);
        exp_addr.delete(); exp_data.delete(); exp_tag.delete();
    endtask

    // compare against the reference on every clock
    always @(negedge clk) begin
        if (running) begin
            if (wr_en) begin
                check(!prev_wr, "R8", "strobe wider than one clock", 2, 1);
                if (exp_addr.size() == 0) begin
                    check(1'b0, "R7", "unexpected write at address", int'(wr_addr), -1);
                end else begin
                    check(int'(wr_addr) == exp_addr[0], exp_tag[0], "write address",
                          int'(wr_addr), exp_addr[0]);
                    check(int'(wr_data) == exp_data[0], exp_tag[0], "write data",
                          int'(wr_data), exp_data[0]);
                    void'(exp_addr.pop_front());
                    void'(exp_data.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
            prev_wr = wr_en;
        end
    end

    task automatic run_all();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(wr_en == 1'b0, "R8", "wr_en after reset", int'(wr_en), 0);
        running = 1'b1;
        repeat (4) @(negedge clk);

        // R4 format a: row, column, data repeated
        xact_begin();
        send(8'h83, "R2"); send(8'h05, "R3"); send(8'hA5, "R4");
        send(8'h89, "R2"); send(8'h17, "R3"); send(8'h3C, "R4");
        xact_finish("R4");

        // R4 format b: one row, then column/data pairs; R2 row replaced before column
        xact_begin();
        send(8'h81, "R2"); send(8'h86, "R2"); send(8'h00, "R3"); send(8'h11, "R4");
        send(8'h1F, "R3"); send(8'hFE, "R4"); send(8'h0A, "R3"); send(8'h7F, "R4");
        xact_finish("R4");

        // R5 bulk with column wrap into the next row
        xact_begin();
        send(8'h81, "R2"); send(8'h5E, "R5");
        send(8'h01, "R5"); send(8'h02, "R5"); send(8'h03, "R5"); send(8'h04, "R5");
        xact_finish("R5");

        // R5 bulk wrap from last row, last column to address 0
        xact_begin();
        send(8'h8F, "R2"); send(8'h5F, "R5"); send(8'hC3, "R5"); send(8'h3C, "R5");
        xact_finish("R5");

        // R6 format a to bulk; row- and bulk-looking bytes stay data
        xact_begin();
        send(8'h82, "R2"); send(8'h04, "R3"); send(8'h55, "R4");
        send(8'h58, "R5"); send(8'h9F, "R6"); send(8'h81, "R6"); send(8'h40, "R6");
        xact_finish("R6");

        // R7 leading non-row bytes ignored in a new transaction
        xact_begin();
        send(8'h05, "R7"); send(8'h33, "R7"); send(8'h47, "R7");
        send(8'h82, "R2"); send(8'h03, "R3"); send(8'h44, "R7");
        xact_finish("R7");

        // R7 bulk does not survive the end of a transaction
        xact_begin();
        send(8'h80, "R2"); send(8'h40, "R5"); send(8'h12, "R5");
        xact_finish("R6");
        xact_begin();
        send(8'h21, "R7"); send(8'h84, "R2"); send(8'h02, "R3"); send(8'h66, "R7");
        xact_finish("R7");

        // R1 partial byte discarded at select high, MSB-first assembly afterwards
        xact_begin();
        spi_bits(8'hFF, 5);
        xact_finish("R1");
        xact_begin();
        send(8'h85, "R1"); send(8'h09, "R1"); send(8'h96, "R1");
        xact_finish("R1");
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (60000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        running = 1'b0;
        if (timed_out) check(1'b0, "R8", "watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule